// File: doc/BRIEF.md
# Receive Packet Delineator with Frame Check

This block sits on a receive byte path. Each cycle it may see one byte, qualified by a valid strobe, along with start and end markers. In framed operation it groups the bytes from a start marker through the matching end marker into one packet. It forwards each packet one cycle later on an output stream that marks the first and last byte. On the last byte it also presents a status word for the packet: whether the trailing four bytes formed a correct CRC-32, and whether the packet began too soon after the one before it.

In unframed operation the markers carry no meaning. Every valid byte is forwarded as part of one endless stream, with no boundaries and no status. A downstream DMA engine uses the first and last marks to open and close buffers, and uses the status to flag bad packets.

Top module: `frame_delineator`

## Requirements
- R1: In framed mode (`unframedMode`=0), every valid byte from a start beat (`inValid`=1, `inSop`=1, no packet open) through the next valid beat with `inEop`=1 appears on `outByte` with `outValid`=1 exactly one cycle later. `outFirst` marks the start byte and `outLast` marks the end byte. Beats with `inValid`=0 inside a packet are skipped, and the packet stays open.
- R2: While a packet is open, a further `inSop` has no effect. The byte is forwarded as an ordinary byte and `outFirst` stays low.
- R3: In framed mode, valid bytes that arrive while no packet is open and without `inSop` are dropped: `outValid` stays low, and an `inEop` on such a beat gives no status.
- R4: In unframed mode, every valid byte is forwarded one cycle later whatever `inSop` and `inEop` say. `outFirst`, `outLast` and `statusValid` stay low.
- R5: `statusValid` is high for exactly the cycle in which `outLast` is high.
- R6: A CRC-32 (reflected polynomial 0xEDB88320, register preset to all ones, bytes fed LSB first) runs over the whole packet, including its four trailing check bytes, which are the complemented CRC of the payload, least significant byte first. With `crcCheckEn`=1 on the end beat, `statusCrcBad` is 0 when the final register equals 0xDEBB20E3 and 1 otherwise.
- R7: With `crcCheckEn`=0 on the end beat, `statusCrcBad` is 0 whatever the data.
- R8: Let an end beat fall in cycle t and the next start beat in cycle t+k. `statusGapShort` on that next packet is 1 when k<7 and 0 when k≥7. The first packet after reset reports 0.
- R9: While reset is asserted, all outputs are 0.
- R10: A beat carrying both `inSop` and `inEop` while no packet is open forms a one-byte packet, with `outFirst`, `outLast` and `statusValid` high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inByte | input | 8 | Received data byte |
| inValid | input | 1 | Byte qualifier |
| inSop | input | 1 | Start-of-packet marker |
| inEop | input | 1 | End-of-packet marker |
| unframedMode | input | 1 | 1 = continuous stream, 0 = framed |
| crcCheckEn | input | 1 | Enables CRC error reporting |
| outByte | output | 8 | Forwarded byte |
| outValid | output | 1 | Output byte qualifier |
| outFirst | output | 1 | First byte of packet |
| outLast | output | 1 | Last byte of packet |
| statusValid | output | 1 | Packet status present |
| statusCrcBad | output | 1 | Check failed |
| statusGapShort | output | 1 | Packet started too soon after previous end |

## Verification
The hardest case to reach is the boundary of the inter-packet gap. A flag that is off by one cycle only shows up when the spacing between an end beat and the next start is exactly six or exactly seven cycles. The stimulus therefore ends one packet and places an exact count of idle beats before the next start: five idle beats give a gap of six, and six idle beats give a gap of seven. Correct check bytes are computed by the stimulus, so the good-frame path is reached. A single flipped bit gives the bad-frame path.

// File: rtl/fd_pkg.sv
`timescale 1ns/1ps
package fd_pkg;
  localparam int BYTE_W = 8;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3;

  typedef struct packed {
    logic startPkt;
    logic takeByte;
    logic endPkt;
    logic gapShort;
  } fdStrobes_t;

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [BYTE_W-1:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/fd_ctrl.sv
`timescale 1ns/1ps
module fd_ctrl
  import fd_pkg::*;
#(
  parameter int MIN_GAP = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inSop,
  input  logic       inEop,
  input  logic       unframedMode,
  output fdStrobes_t strb
);
  localparam int CNT_W = $clog2(MIN_GAP + 1);
  localparam logic [CNT_W-1:0] GAP_LIM = CNT_W'(MIN_GAP);

  logic             inPkt;
  logic [CNT_W-1:0] gapCnt;

  always_comb begin
    strb = '0;
    if (unframedMode) begin
      strb.takeByte = inValid;
    end else begin
      strb.startPkt = inValid & inSop & ~inPkt;
      strb.takeByte = inValid & (inPkt | inSop);
      strb.endPkt   = inValid & (inPkt | inSop) & inEop;
      strb.gapShort = strb.startPkt & (gapCnt < GAP_LIM);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPkt  <= 1'b0;
      gapCnt <= GAP_LIM;
    end else begin
      if (unframedMode)      inPkt <= 1'b0;
      else if (strb.endPkt)  inPkt <= 1'b0;
      else if (strb.startPkt) inPkt <= 1'b1;

      if (strb.endPkt)            gapCnt <= CNT_W'(1);
      else if (gapCnt != GAP_LIM) gapCnt <= gapCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/fd_datapath.sv
`timescale 1ns/1ps
module fd_datapath
  import fd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              crcCheckEn,
  input  fdStrobes_t        strb,
  output logic [BYTE_W-1:0] outByte,
  output logic              outValid,
  output logic              outFirst,
  output logic              outLast,
  output logic              statusValid,
  output logic              statusCrcBad,
  output logic              statusGapShort
);
  logic [31:0] crcReg;
  logic [31:0] crcNext;
  logic        gapLatch;

  always_comb crcNext = crcStep(strb.startPkt ? 32'hFFFF_FFFF : crcReg, inByte);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg         <= '1;
      gapLatch       <= 1'b0;
      outByte        <= '0;
      outValid       <= 1'b0;
      outFirst       <= 1'b0;
      outLast        <= 1'b0;
      statusValid    <= 1'b0;
      statusCrcBad   <= 1'b0;
      statusGapShort <= 1'b0;
    end else begin
      if (strb.takeByte) begin
        crcReg  <= crcNext;
        outByte <= inByte;
      end
      if (strb.startPkt) gapLatch <= strb.gapShort;
      outValid       <= strb.takeByte;
      outFirst       <= strb.startPkt;
      outLast        <= strb.endPkt;
      statusValid    <= strb.endPkt;
      statusCrcBad   <= strb.endPkt & crcCheckEn & (crcNext != CRC_RESIDUE);
      statusGapShort <= strb.endPkt & (strb.startPkt ? strb.gapShort : gapLatch);
    end
  end
endmodule

// File: rtl/frame_delineator.sv
`timescale 1ns/1ps
module frame_delineator
  import fd_pkg::*;
#(
  parameter int MIN_GAP = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inEop,
  input  logic              unframedMode,
  input  logic              crcCheckEn,
  output logic [BYTE_W-1:0] outByte,
  output logic              outValid,
  output logic              outFirst,
  output logic              outLast,
  output logic              statusValid,
  output logic              statusCrcBad,
  output logic              statusGapShort
);
  fdStrobes_t strb;

  fd_ctrl #(.MIN_GAP(MIN_GAP)) ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop),
    .inEop(inEop), .unframedMode(unframedMode), .strb(strb)
  );

  fd_datapath dp (
    .clk(clk), .rstN(rstN), .inByte(inByte), .crcCheckEn(crcCheckEn),
    .strb(strb), .outByte(outByte), .outValid(outValid),
    .outFirst(outFirst), .outLast(outLast), .statusValid(statusValid),
    .statusCrcBad(statusCrcBad), .statusGapShort(statusGapShort)
  );
endmodule

// File: rtl/fd_chk.sv
`timescale 1ns/1ps
module fd_chk
  import fd_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [BYTE_W-1:0] inByte,
  input logic              inValid,
  input logic              inSop,
  input logic              inEop,
  input logic              unframedMode,
  input logic              crcCheckEn,
  input logic [BYTE_W-1:0] outByte,
  input logic              outValid,
  input logic              outFirst,
  input logic              outLast,
  input logic              statusValid,
  input logic              statusCrcBad,
  input logic              statusGapShort
);
  logic openOut;
  always_ff @(posedge clk) begin
    if (!rstN)                     openOut <= 1'b0;
    else if (outLast)              openOut <= 1'b0;
    else if (outFirst)             openOut <= 1'b1;
  end

  // R1
  data_follows_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outByte == $past(inByte));
  // R1
  first_has_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outFirst || outLast) |-> outValid);
  // R2
  no_nested_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    outFirst |-> !openOut);
  // R3
  no_stray_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !openOut && !outFirst) |-> $past(unframedMode));
  // R4
  unframed_no_marks_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(unframedMode) |-> (!outFirst && !outLast && !statusValid));
  // R7
  crc_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusCrcBad |-> (statusValid && $past(crcCheckEn)));
  // R8
  gap_with_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusGapShort |-> statusValid);
endmodule

bind frame_delineator fd_chk chk (.*);

// File: tb/frame_delineator_test.sv
`timescale 1ns/1ps
module frame_delineator_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] inByte = '0;
  logic       inValid = 1'b0, inSop = 1'b0, inEop = 1'b0;
  logic       unframedMode = 1'b0, crcCheckEn = 1'b0;
  logic [7:0] outByte;
  logic       outValid, outFirst, outLast, statusValid, statusCrcBad, statusGapShort;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic [7:0] pkt [0:63];

  always #2.5 clk = ~clk;

  frame_delineator uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic beat(input logic [7:0] b, input bit v, input bit s, input bit e);
    inByte = b; inValid = v; inSop = s; inEop = e;
    @(posedge clk); #1;
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      beat(8'h00, 1'b0, 1'b0, 1'b0);
      check("R3 idle no output", outValid, 0);
    end
  endtask

  task automatic sendPkt(input int len, input bit corrupt, input bit en, input bit expGap, input int seed);
    logic [31:0] c = 32'hFFFF_FFFF;
    int total = len + 4;
    for (int i = 0; i < len; i++) begin
      pkt[i] = 8'((seed * 37 + i * 11) ^ (i << 3));
      c = crcByte(c, pkt[i]);
    end
    c = ~c;
    for (int i = 0; i < 4; i++) pkt[len + i] = c[8*i +: 8];
    if (corrupt) pkt[len] = pkt[len] ^ 8'h04;
    crcCheckEn = en;
    for (int i = 0; i < total; i++) begin
      beat(pkt[i], 1'b1, i == 0, i == total - 1);
      check("R1 valid", outValid, 1);
      check("R1 byte", outByte, pkt[i]);
      check("R1 first", outFirst, i == 0);
      check("R1 last", outLast, i == total - 1);
      check("R5 status with last", statusValid, i == total - 1);
    end
    check(en ? "R6 crc result" : "R7 crc bypass", statusCrcBad, en & corrupt);
    check("R8 gap flag", statusGapShort, expGap);
  endtask

  task automatic testReset();
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset outputs", {outByte, outValid, outFirst, outLast, statusValid, statusCrcBad, statusGapShort}, 0);
    rstN = 1'b1;
  endtask

  task automatic testCrc();
    idle(8);
    sendPkt(8, 1'b0, 1'b1, 1'b0, 1);
    idle(6);
    sendPkt(8, 1'b1, 1'b1, 1'b0, 2);
    idle(6);
    sendPkt(5, 1'b1, 1'b0, 1'b0, 3);
  endtask

  task automatic testGap();
    idle(5);
    sendPkt(4, 1'b0, 1'b1, 1'b1, 4);
    idle(6);
    sendPkt(4, 1'b0, 1'b1, 1'b0, 5);
  endtask

  task automatic testNestedSop();
    crcCheckEn = 1'b0;
    idle(7);
    beat(8'hA1, 1, 1, 0);
    check("R2 first byte", outFirst, 1);
    beat(8'hA2, 1, 1, 0);
    check("R2 inner sop ignored first", outFirst, 0);
    check("R2 inner sop byte kept", outValid, 1);
    beat(8'hA3, 0, 1, 0);
    check("R1 invalid beat skipped", outValid, 0);
    beat(8'hA4, 1, 0, 1);
    check("R1 close byte", outByte, 8'hA4);
    check("R2 close last", outLast, 1);
  endtask

  task automatic testDiscard();
    beat(8'hB1, 1, 0, 0);
    check("R3 stray byte dropped", outValid, 0);
    beat(8'hB2, 1, 0, 1);
    check("R3 stray eop dropped", outValid, 0);
    check("R3 stray eop no status", statusValid, 0);
  endtask

  task automatic testSingle();
    idle(7);
    beat(8'hC5, 1, 1, 1);
    check("R10 single first", outFirst, 1);
    check("R10 single last", outLast, 1);
    check("R10 single status", statusValid, 1);
    check("R10 single byte", outByte, 8'hC5);
  endtask

  task automatic testUnframed();
    unframedMode = 1'b1;
    crcCheckEn = 1'b1;
    for (int i = 0; i < 6; i++) begin
      beat(8'(8'h30 + i), 1, i % 2 == 0, i % 3 == 1);
      check("R4 byte valid", outValid, 1);
      check("R4 byte value", outByte, 8'(8'h30 + i));
      check("R4 no marks", {outFirst, outLast, statusValid}, 0);
    end
    beat(8'h77, 0, 1, 1);
    check("R4 invalid dropped", outValid, 0);
    unframedMode = 1'b0;
    idle(2);
  endtask

  initial begin
    testReset();
    testCrc();
    testGap();
    testNestedSop();
    testDiscard();
    testSingle();
    testUnframed();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1'b1;
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule